// File: doc/BRIEF.md
# Multiphase Edge-Counting Time Interval Meter

This block measures the time between a start event and a stop event with a step much finer than one clock period. It receives sixteen copies of a 400 MHz clock. Each copy is delayed from the one before it by 1/32 of the 2.5 ns period. Every rising edge and every falling edge of every copy drives its own counter, so the design has 32 counters. Their edges interleave evenly, 78.125 ps apart. The sum of all 32 counts therefore acts like one counter running at 12.8 GHz. The interval in picoseconds is the sum times 78.125.

Each counter lane samples the start and stop inputs through its own synchronizer and counts only while its local window is open. Every lane has the same synchronizer latency, so each window is offset by the same amount and the total count is kept. A sequencer in the system clock domain works as follows:

- It detects the start and then the stop.
- It waits for the lanes to freeze.
- It adds the 32 counts one per cycle into a wider accumulator.
- It presents the result with a valid flag.
- It briefly disarms the lanes to clear them for the next measurement.

Start and stop are levels, each held high for at least two system clock cycles. Stop may rise while start is still high.

Top module: `phase_tdc`

## Requirements
- R1: After reset, `interval_count` is 0 and `count_valid` and `busy` are both low.
- R2: `busy` is high within four system cycles after `meas_start` rises while idle, with `count_valid` low. It stays high until the cycle in which `count_valid` rises.
- R3: For an interval T between the rise of `meas_start` and the rise of `meas_stop`, the completed `interval_count` is within one count of T / 78.125 ps.
- R4: Intervals shorter than one 2.5 ns phase period are resolved in 78.125 ps steps. For example, intervals of 1 and 5 steps give 1 and 5, each within one count.
- R5: Long intervals spanning thousands of phase periods are counted without loss. An interval of 90000 steps gives 90000 within one count.
- R6: A rise of `meas_start` while `busy` is high is ignored. The result still measures from the first start.
- R7: A `meas_stop` pulse with no measurement in progress is ignored. `busy` stays low, and `count_valid` and `interval_count` keep their values.
- R8: Once high, `count_valid` stays high and `interval_count` stays unchanged until the next accepted start. That start drops `count_valid`.
- R9: `count_valid` and `busy` are never high in the same cycle.
- R10: Driving `rst_n` low in the middle of a measurement clears the result and both flags. A following measurement is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | N_PHASES (16) | Phase-shifted 400 MHz clocks, adjacent phases 78.125 ps apart |
| sys_clk | input | 1 | System clock for sequencing and summation |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_start | input | 1 | Start event, level, rising edge marks the start time |
| meas_stop | input | 1 | Stop event, level, rising edge marks the stop time |
| interval_count | output | CNT_W+5 (41) | Sum of all lane counts, in 78.125 ps steps |
| count_valid | output | 1 | Result complete and held |
| busy | output | 1 | Measurement or summation in progress |

## Verification
The table-driven part applies intervals of 1, 5, 31, 32, 33, 257, 4000 and 90000 steps, with start times at varied positions relative to the phase lattice. Lengths below, at and just above one full period (32 steps) show whether rising and falling lanes both contribute and whether the lanes interleave correctly. The shortest lengths separate true sub-period resolution from a design that only counts whole periods. The longest show that no carry or summation term is dropped. The directed cases are:

- a second start inside the window, which tells a latched start apart from a restartable one;
- a stop with no start, which must leave the held result untouched;
- a reset in mid-flight, which must clear the state so that the next measurement is clean.

// File: rtl/tdc_pkg.sv
`timescale 1ps/1fs
package tdc_pkg;
  localparam int DEF_PHASES = 16;
  localparam int DEF_CNT_W  = 36;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_SUM   = 3'd3,
    ST_CLEAR = 3'd4
  } tdc_state_e;
endpackage

// File: rtl/tdc_lane.sv
`timescale 1ps/1fs
// One counting lane: counts the chosen edge of one phase clock while its
// locally sampled measurement window is open.
module tdc_lane #(
  parameter int CNT_W       = 36,
  parameter bit FALLING     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ph_clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o
);
  logic lane_clk;

  generate
    if (FALLING) begin : g_fall
      assign lane_clk = ~ph_clk;
    end else begin : g_rise
      assign lane_clk = ph_clk;
    end
  endgenerate

  // reset: asserted asynchronously, released on the lane's own edge
  logic [1:0] rst_pipe;
  logic       lane_rst_n;

  always_ff @(posedge lane_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign lane_rst_n = rst_pipe[1];

  // input synchronizers, identical depth for start and stop
  logic [SYNC_STAGES-1:0] arm_sh, start_sh, stop_sh;
  logic arm_s, start_s, stop_s;

  always_ff @(posedge lane_clk or negedge lane_rst_n) begin
    if (!lane_rst_n) begin
      arm_sh   <= '0;
      start_sh <= '0;
      stop_sh  <= '0;
    end else begin
      arm_sh   <= {arm_sh[SYNC_STAGES-2:0], arm};
      start_sh <= {start_sh[SYNC_STAGES-2:0], start_i};
      stop_sh  <= {stop_sh[SYNC_STAGES-2:0], stop_i};
    end
  end
  assign arm_s   = arm_sh[SYNC_STAGES-1];
  assign start_s = start_sh[SYNC_STAGES-1];
  assign stop_s  = stop_sh[SYNC_STAGES-1];

  logic             active_q, active_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    if (!arm_s) begin
      active_d = 1'b0;
      done_d   = 1'b0;
      cnt_d    = '0;
    end else begin
      if (active_q) cnt_d = cnt_q + CNT_W'(1);
      if (stop_s) begin
        active_d = 1'b0;
        if (active_q || start_s) done_d = 1'b1;
      end else if (start_s && !done_q) begin
        active_d = 1'b1;
      end
    end
  end

  always_ff @(posedge lane_clk or negedge lane_rst_n) begin
    if (!lane_rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tdc_seq.sv
`timescale 1ps/1fs
// System-side sequencer: event detection, drain wait, serial summation,
// result hold and lane clearing.
module tdc_seq
  import tdc_pkg::*;
#(
  parameter int N_CNT     = 32,
  parameter int CNT_W     = 36,
  parameter int SUM_W     = 41,
  parameter int DRAIN_CYC = 4,
  parameter int CLEAR_CYC = 4
) (
  input  logic                        sys_clk,
  input  logic                        rst_n,
  input  logic                        meas_start,
  input  logic                        meas_stop,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_bus,
  output logic                        arm,
  output logic [SUM_W-1:0]            result,
  output logic                        valid,
  output logic                        busy
);
  localparam int IDX_W  = $clog2(N_CNT);
  localparam int STEP_W = $clog2(N_CNT + DRAIN_CYC + CLEAR_CYC + 1);

  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic [2:0] st_sh;
  logic [1:0] sp_sh;
  logic       start_rise, stop_lvl;

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      st_sh <= '0;
      sp_sh <= '0;
    end else begin
      st_sh <= {st_sh[1:0], meas_start};
      sp_sh <= {sp_sh[0], meas_stop};
    end
  end
  assign start_rise = st_sh[1] & ~st_sh[2];
  assign stop_lvl   = sp_sh[1];

  tdc_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [SUM_W-1:0]  acc_q, acc_d;
  logic [SUM_W-1:0]  res_q, res_d;
  logic              val_q, val_d;
  logic              arm_q, arm_d;
  logic [CNT_W-1:0]  sel_cnt;

  assign sel_cnt = cnt_bus[step_q[IDX_W-1:0]];

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    acc_d   = acc_q;
    res_d   = res_q;
    val_d   = val_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rise) begin
          state_d = ST_RUN;
          val_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (stop_lvl) begin
          state_d = ST_DRAIN;
          step_d  = '0;
        end
      end
      ST_DRAIN: begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(DRAIN_CYC - 1)) begin
          state_d = ST_SUM;
          step_d  = '0;
          acc_d   = '0;
        end
      end
      ST_SUM: begin
        acc_d  = acc_q + SUM_W'(sel_cnt);
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(N_CNT - 1)) begin
          res_d   = acc_d;
          val_d   = 1'b1;
          state_d = ST_CLEAR;
          step_d  = '0;
        end
      end
      ST_CLEAR: begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(CLEAR_CYC - 1)) begin
          state_d = ST_IDLE;
          step_d  = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    arm_d = (state_d != ST_CLEAR);
  end

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      val_q   <= 1'b0;
      arm_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      acc_q   <= acc_d;
      res_q   <= res_d;
      val_q   <= val_d;
      arm_q   <= arm_d;
    end
  end

  assign arm    = arm_q;
  assign result = res_q;
  assign valid  = val_q;
  assign busy   = (state_q == ST_RUN) || (state_q == ST_DRAIN) || (state_q == ST_SUM);
endmodule

// File: rtl/phase_tdc.sv
`timescale 1ps/1fs
module phase_tdc
  import tdc_pkg::*;
#(
  parameter int N_PHASES    = DEF_PHASES,
  parameter int CNT_W       = DEF_CNT_W,
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_CYC   = 4,
  parameter int CLEAR_CYC   = 4,
  localparam int N_CNT      = 2 * N_PHASES,
  localparam int SUM_W      = CNT_W + $clog2(N_CNT)
) (
  input  logic [N_PHASES-1:0] phase_clk,
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                meas_start,
  input  logic                meas_stop,
  output logic [SUM_W-1:0]    interval_count,
  output logic                count_valid,
  output logic                busy
);
  logic [N_CNT-1:0][CNT_W-1:0] cnt_bus;
  logic                        lane_arm;

  // lanes 0..N_PHASES-1 count rising edges, the rest falling edges
  for (genvar e = 0; e < N_CNT; e++) begin : g_lane
    tdc_lane #(
      .CNT_W      (CNT_W),
      .FALLING    (e >= N_PHASES),
      .SYNC_STAGES(SYNC_STAGES)
    ) lane_i (
      .ph_clk (phase_clk[e % N_PHASES]),
      .rst_n  (rst_n),
      .arm    (lane_arm),
      .start_i(meas_start),
      .stop_i (meas_stop),
      .count_o(cnt_bus[e])
    );
  end

  tdc_seq #(
    .N_CNT    (N_CNT),
    .CNT_W    (CNT_W),
    .SUM_W    (SUM_W),
    .DRAIN_CYC(DRAIN_CYC),
    .CLEAR_CYC(CLEAR_CYC)
  ) seq_i (
    .sys_clk   (sys_clk),
    .rst_n     (rst_n),
    .meas_start(meas_start),
    .meas_stop (meas_stop),
    .cnt_bus   (cnt_bus),
    .arm       (lane_arm),
    .result    (interval_count),
    .valid     (count_valid),
    .busy      (busy)
  );
endmodule

// File: rtl/phase_tdc_checker.sv
`timescale 1ps/1fs
module phase_tdc_checker #(
  parameter int SUM_W = 41
) (
  input logic             sys_clk,
  input logic             rst_n,
  input logic             busy,
  input logic             count_valid,
  input logic [SUM_W-1:0] interval_count
);
  assert_flags_exclusive_R9: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(count_valid && busy));

  assert_busy_until_valid_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    busy |=> (busy || count_valid));

  assert_result_held_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    count_valid |=> (!count_valid || $stable(interval_count)));

  assert_valid_after_busy_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(count_valid) |-> $past(busy));
endmodule

bind phase_tdc phase_tdc_checker #(.SUM_W(SUM_W)) chk_i (
  .sys_clk       (sys_clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .count_valid   (count_valid),
  .interval_count(interval_count)
);

// File: tb/phase_tdc_tb_top.sv
`timescale 1ps/1fs
module phase_tdc_tb_top;
  localparam int    NPH    = 16;
  localparam int    CW     = 36;
  localparam int    SW     = CW + 5;
  localparam real   STEP   = 78.125;
  localparam real   SYS_HP = 10000.0;
  localparam int    NVEC   = 8;
  localparam int    VEC_LEN [NVEC] = '{1, 5, 31, 32, 33, 257, 4000, 90000};
  localparam int    VEC_SKEW[NVEC] = '{2, 7, 11, 3, 20, 5, 13, 9};

  logic [NPH-1:0] phase_clk;
  logic           sys_clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           meas_start = 1'b0;
  logic           meas_stop = 1'b0;
  logic [SW-1:0]  interval_count;
  logic           count_valid;
  logic           busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(SYS_HP) sys_clk = ~sys_clk;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic ck = 1'b0;
    initial begin
      #(k * STEP);
      forever #1250.0 ck = ~ck;
    end
    assign phase_clk[k] = ck;
  end

  phase_tdc dut_i (
    .phase_clk     (phase_clk),
    .sys_clk       (sys_clk),
    .rst_n         (rst_n),
    .meas_start    (meas_start),
    .meas_stop     (meas_stop),
    .interval_count(interval_count),
    .count_valid   (count_valid),
    .busy          (busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // start on a lattice point plus 39 ps, so no phase edge coincides
  task automatic launch(input int skew);
    real t0, ts;
    int a;
    t0 = $realtime;
    a  = int'($ceil(t0 / STEP)) + skew;
    ts = a * STEP + 39.0;
    #(ts - t0);
    meas_start = 1'b1;
  endtask

  task automatic measure(input int len, input int skew, input bit restart);
    launch(skew);
    fork
      begin
        #50000.0 meas_start = 1'b0;
        if (restart) begin
          #50000.0 meas_start = 1'b1;
          #50000.0 meas_start = 1'b0;
        end
      end
      begin
        #(len * STEP) meas_stop = 1'b1;
        #50000.0 meas_stop = 1'b0;
      end
    join
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400; i++) begin
      @(negedge sys_clk);
      if (count_valid) break;
    end
  endtask

  function automatic bit near(input longint act, input longint exp);
    return (act >= exp - 1) && (act <= exp + 1);
  endfunction

  initial begin
    #(2.0e9);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    longint held;
    repeat (4) @(negedge sys_clk);
    // R1: reset state
    chk(interval_count == '0, "R1 count", longint'(interval_count), 0);
    chk(!count_valid && !busy, "R1 flags", {count_valid, busy}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge sys_clk);

    // R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      fork
        measure(VEC_LEN[v], VEC_SKEW[v], 1'b0);
        begin
          if (v == 0) begin
            #1.0;
            repeat (4) @(negedge sys_clk);
            // R2: busy follows start, valid dropped
            chk(busy && !count_valid, "R2 busy after start", {busy, count_valid}, 2);
          end
        end
      join
      wait_valid();
      chk(count_valid, "R3 completion", count_valid, 1);
      chk(near(longint'(interval_count), VEC_LEN[v]),
          (VEC_LEN[v] < 32) ? "R4 sub-period interval" :
          (VEC_LEN[v] > 1000) ? "R5 long interval" : "R3 interval",
          longint'(interval_count), VEC_LEN[v]);
      repeat (8) @(negedge sys_clk);
    end

    // R8: result held while idle
    held = longint'(interval_count);
    repeat (20) @(negedge sys_clk);
    chk(count_valid && longint'(interval_count) == held, "R8 hold", longint'(interval_count), held);

    // R7: stop alone while idle is ignored
    meas_stop = 1'b1;
    repeat (3) @(negedge sys_clk);
    meas_stop = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk(!busy, "R7 busy", busy, 0);
    chk(count_valid && longint'(interval_count) == held, "R7 result", longint'(interval_count), held);
    repeat (4) @(negedge sys_clk);

    // R6: second start inside the window ignored; R8 valid drops on accepted start
    fork
      measure(3000, 4, 1'b1);
      begin
        #1.0;
        repeat (4) @(negedge sys_clk);
        chk(!count_valid, "R8 valid drops", count_valid, 0);
      end
    join
    wait_valid();
    chk(near(longint'(interval_count), 3000), "R6 restart ignored", longint'(interval_count), 3000);
    repeat (8) @(negedge sys_clk);

    // R10: reset mid-measurement
    launch(6);
    repeat (5) @(negedge sys_clk);
    meas_start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk(interval_count == '0 && !count_valid && !busy, "R10 cleared",
        longint'(interval_count) + count_valid + busy, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge sys_clk);
    measure(500, 8, 1'b0);
    wait_valid();
    chk(near(longint'(interval_count), 500), "R10 after reset", longint'(interval_count), 500);
    report();
  end
endmodule